// File: doc/BRIEF.md
# Programmable I/O Pad Cell

This block models one configurable input/output cell that sits between internal logic and a bidirectional pad. Core logic supplies outgoing data and an output-enable request. The cell returns what it sees on the pad. A small configuration word sets the pin's role: receive only, always drive, drive under an enable, or both drive and receive on the same wire.

Each role can use a one-bit storage stage or skip it. When the stage is in use, the outgoing data, the enable and the incoming pad value are each held in a flip-flop on the rising clock edge. This gives pad timing that is aligned to the clock. When the stage is skipped, every path is combinational, so the pad and the core see each other in the same cycle.

A synchronous reset clears all three flip-flops. A cell that uses the storage stage therefore leaves its pad floating once reset has been applied.

Top module: `io_pad_cell`

## Requirements
- R1: The configuration word is {use_reg, role[1:0]}: bit 2 selects the storage stage (1 = registered), and role 00 = receive only, 01 = always drive, 10 = drive under enable, 11 = bidirectional.
- R2: In receive-only role the cell never drives the pad, whatever `core_dout` and `core_oe` are, and `core_din` carries the pad value.
- R3: In always-drive role the pad is driven with `core_dout` and `core_oe` is ignored.
- R4: In drive-under-enable role the pad is driven with `core_dout` while `core_oe` is 1 and left undriven while it is 0.
- R5: In bidirectional role the pad is driven as in R4, and `core_din` carries the pad value even while the cell drives it (readback).
- R6: With use_reg = 0, a change of `core_dout`, `core_oe` or the pad reaches the other side in the same cycle.
- R7: With use_reg = 1, outgoing data and enable appear on the pad only after the next rising clock edge, and a pad value reaches `core_din` only after the next rising clock edge.
- R8: While `rst` is 1 at a rising edge, the stored enable, data and input bits are cleared, so a registered cell leaves the pad undriven and returns 0 on `core_din`.
- R9: In always-drive and drive-under-enable roles `core_din` is held at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the storage stage |
| rst | input | 1 | Synchronous reset, active high |
| cfg | input | 3 | Configuration word {use_reg, role[1:0]} |
| core_dout | input | 1 | Data from core logic toward the pad |
| core_oe | input | 1 | Output-enable request from core logic |
| core_din | output | 1 | Pad value returned to core logic |
| pad | inout | 1 | Bidirectional pad |

## Verification
A wrong stored enable shows up on the pad in the same cycle. It appears either as a pad driven when it should float or as a pad that fails to follow `core_dout`. A stale stored data bit or input bit is visible one clock after the value it should have held. The bench therefore samples on both sides of each rising edge in registered mode. A decode fault in the role field shows up at once in combinational mode, as a wrong drive or as a non-zero `core_din` in a drive-only role.

// File: rtl/iocell_pkg.sv
package iocell_pkg;

  typedef enum logic [1:0] {
    ROLE_RECV  = 2'b00,
    ROLE_DRIVE = 2'b01,
    ROLE_GATED = 2'b10,
    ROLE_BIDIR = 2'b11
  } pin_role_e;

  typedef struct packed {
    logic      use_reg;
    pin_role_e role;
  } cell_cfg_t;

  localparam int CFG_BITS = $bits(cell_cfg_t);

  // Whether the driver should be on for a given role and enable request.
  function automatic logic drive_wanted(pin_role_e role, logic oe_req);
    case (role)
      ROLE_RECV:  return 1'b0;
      ROLE_DRIVE: return 1'b1;
      default:    return oe_req;
    endcase
  endfunction

  // Whether the pad value is passed back to the core.
  function automatic logic sense_wanted(pin_role_e role);
    return (role == ROLE_RECV) || (role == ROLE_BIDIR);
  endfunction

endpackage

// File: rtl/io_role_decode.sv
module io_role_decode
  import iocell_pkg::*;
(
  input  logic [CFG_BITS-1:0] cfg_raw,
  input  logic                oe_req,
  output logic                use_reg,
  output logic                drive_en,
  output logic                sense_en
);
  cell_cfg_t cfg_s;

  always_comb begin
    cfg_s    = cell_cfg_t'(cfg_raw);
    use_reg  = cfg_s.use_reg;
    drive_en = drive_wanted(cfg_s.role, oe_req);
    sense_en = sense_wanted(cfg_s.role);
  end
endmodule

// File: rtl/io_opt_stage.sv
module io_opt_stage #(
  parameter int              WIDTH     = 1,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             use_reg,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q_held,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q_held <= RESET_VAL;
    else     q_held <= d;
  end

  assign q = use_reg ? q_held : d;
endmodule

// File: rtl/io_pad_cell.sv
module io_pad_cell
  import iocell_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [CFG_BITS-1:0] cfg,
  input  logic                core_dout,
  input  logic                core_oe,
  output logic                core_din,
  inout  wire                 pad
);
  localparam int OUT_W = 2;  // {enable, data}

  logic             use_reg;
  logic             drive_en;
  logic             sense_en;
  logic [OUT_W-1:0] out_req;
  logic [OUT_W-1:0] out_held;
  logic [OUT_W-1:0] out_eff;
  logic             oe_eff;
  logic             dout_eff;
  logic             pad_in;
  logic             in_held;
  logic             in_src;

  io_role_decode u_dec (
    .cfg_raw  (cfg),
    .oe_req   (core_oe),
    .use_reg  (use_reg),
    .drive_en (drive_en),
    .sense_en (sense_en)
  );

  assign out_req = {drive_en, core_dout};

  io_opt_stage #(.WIDTH(OUT_W), .RESET_VAL('0)) u_out_stage (
    .clk     (clk),
    .rst     (rst),
    .use_reg (use_reg),
    .d       (out_req),
    .q_held  (out_held),
    .q       (out_eff)
  );

  assign oe_eff   = out_eff[1];
  assign dout_eff = out_eff[0];
  assign pad      = oe_eff ? dout_eff : 1'bz;
  assign pad_in   = pad;

  io_opt_stage #(.WIDTH(1), .RESET_VAL(1'b0)) u_in_stage (
    .clk     (clk),
    .rst     (rst),
    .use_reg (use_reg),
    .d       (pad_in),
    .q_held  (in_held),
    .q       (in_src)
  );

  assign core_din = sense_en & in_src;
endmodule

// File: rtl/io_pad_cell_chk.sv
module io_pad_cell_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] cfg,
  input logic       core_dout,
  input logic       core_oe,
  input logic       core_din,
  input logic       oe_eff,
  input logic       dout_eff,
  input logic       pad_in,
  input logic [1:0] out_held,
  input logic       in_held
);
  // R2: receive-only role never enables the driver (combinational case)
  p_recv_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg == 3'b000) |-> !oe_eff);

  // R3: always-drive role drives current data when unregistered
  p_drive_on_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg == 3'b001) |-> (oe_eff && dout_eff == core_dout));

  // R4: gated role follows the core enable when unregistered
  p_gated_oe_r4: assert property (@(posedge clk) disable iff (rst)
    (cfg == 3'b010) |-> (oe_eff == core_oe));

  // R5: bidirectional readback when unregistered
  p_readback_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg == 3'b011) |-> (core_din == pad_in));

  // R7: stored data bit is the previous cycle's core data
  p_capture_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_held[0] == $past(core_dout)));

  // R8: reset clears stored enable and input bit
  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (out_held[1] == 1'b0 && in_held == 1'b0));

  // R9: drive-only roles return zero to the core
  p_din_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (cfg[1:0] == 2'b01 || cfg[1:0] == 2'b10) |-> (core_din == 1'b0));
endmodule

bind io_pad_cell io_pad_cell_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg       (cfg),
  .core_dout (core_dout),
  .core_oe   (core_oe),
  .core_din  (core_din),
  .oe_eff    (oe_eff),
  .dout_eff  (dout_eff),
  .pad_in    (pad_in),
  .out_held  (out_held),
  .in_held   (in_held)
);

// File: tb/io_pad_cell_bench.sv
module io_pad_cell_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cfg = 3'b000;
  logic       core_dout = 1'b0;
  logic       core_oe = 1'b0;
  logic       core_din;
  logic       tb_en = 1'b0;
  logic       tb_val = 1'b0;
  wire        pad;

  int errors = 0;
  int checks = 0;

  assign pad = tb_en ? tb_val : 1'bz;

  always #4 clk = ~clk;  // 125 MHz

  io_pad_cell u_io_pad_cell (
    .clk       (clk),
    .rst       (rst),
    .cfg       (cfg),
    .core_dout (core_dout),
    .core_oe   (core_oe),
    .core_din  (core_din),
    .pad       (pad)
  );

  // {cfg[2:0], dout, oe, tb_en, tb_val, chk_pad, exp_pad, exp_din}
  // Float is shown by the bench driving the value opposite to core_dout and reading it back.
  localparam int NV = 12;
  localparam logic [9:0] VEC [NV] = '{
    10'b000_1_1_1_0_1_0_0,  // R2 recv: not driven, din 0
    10'b000_0_1_1_1_1_1_1,  // R2 recv: din follows pad
    10'b001_1_0_0_0_1_1_0,  // R3 drive 1, oe ignored, R9
    10'b001_0_0_0_0_1_0_0,  // R3 drive 0
    10'b010_1_1_0_0_1_1_0,  // R4 gated on, R9
    10'b010_0_1_0_0_1_0_0,  // R4 gated on, data 0
    10'b010_1_0_1_0_1_0_0,  // R4 gated off floats
    10'b011_1_1_0_0_1_1_1,  // R5 readback 1
    10'b011_0_1_0_0_1_0_0,  // R5 readback 0
    10'b011_0_0_1_1_1_1_1,  // R5 receive 1 while off
    10'b011_1_0_1_0_1_0_0,  // R5 off floats
    10'b000_0_0_1_1_1_1_1   // R6 recv same cycle
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // reset with a registered always-drive config
    cfg = 3'b101; core_dout = 1'b1; tb_en = 1'b1; tb_val = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R8 pad undriven after reset", pad, 1'b0);
    check("R8 din zero after reset", core_din, 1'b0);
    rst = 1'b0;

    // combinational vector table (R1, R6)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cfg = VEC[i][9:7]; core_dout = VEC[i][6]; core_oe = VEC[i][5];
      tb_en = VEC[i][4]; tb_val = VEC[i][3];
      #1;
      if (VEC[i][2]) check($sformatf("R1/R6 vec%0d pad", i), pad, VEC[i][1]);
      check($sformatf("R1/R6 vec%0d din", i), core_din, VEC[i][0]);
    end

    // R7 registered output: data/oe reach pad only after the edge
    @(negedge clk);
    cfg = 3'b010; core_oe = 1'b0; core_dout = 1'b0; tb_en = 1'b0;
    @(negedge clk);
    cfg = 3'b110;
    @(negedge clk);  // stored enable is now 0
    core_oe = 1'b1; core_dout = 1'b1; tb_en = 1'b1; tb_val = 1'b0;
    #2;
    check("R7 pad still undriven before edge", pad, 1'b0);
    @(posedge clk); #1; tb_en = 1'b0; #1;
    check("R7 pad driven after edge", pad, 1'b1);
    @(negedge clk);
    core_dout = 1'b0; #2;
    check("R7 pad holds stored data", pad, 1'b1);
    @(posedge clk); #2;
    check("R7 pad takes new data after edge", pad, 1'b0);

    // R7 registered input path
    @(negedge clk);
    cfg = 3'b100; tb_en = 1'b1; tb_val = 1'b0;
    @(negedge clk);
    @(negedge clk);
    tb_val = 1'b1; #2;
    check("R7 din delayed before edge", core_din, 1'b0);
    @(posedge clk); #2;
    check("R7 din updated after edge", core_din, 1'b1);

    // R5 registered readback in bidirectional role
    @(negedge clk);
    tb_en = 1'b0; cfg = 3'b111; core_oe = 1'b1; core_dout = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R5 registered readback", core_din, 1'b1);

    // R8 reset returns registered cell to floating
    rst = 1'b1;
    @(posedge clk); #1;
    tb_en = 1'b1; tb_val = 1'b0; #1;
    check("R8 pad floats after reset edge", pad, 1'b0);
    rst = 1'b0;

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule